// File: doc/BRIEF.md
# Parallel Window Access Image Memory

This block holds a two-dimensional image of `ROWS` x `COLS` pixels and, given only the top-left corner of a window, returns all `WIN_H` x `WIN_W` pixels of that window together in one read. Any origin that keeps the window inside the image is legal, including origins whose column is not a multiple of the window width. Pixels are loaded one at a time through a synchronous write port.

The image columns are interleaved over `WIN_W` banks, so the `WIN_W` columns of any window always fall in distinct banks. One row decoder is shared by all banks. It turns the window's origin row into `WIN_H` adjacent active wordlines. Each bank has its own column select, which picks the single pixel it owes to each active row. A final crossbar puts the bank outputs back into window order before the result is registered.

Top module: `pwin_mem`

## Requirements
- R1: `win_valid` is high in the cycle after a cycle with `rd_en` high, and low in the cycle after a cycle with `rd_en` low.
- R2: After a read with origin row `y` and column `x` that fits in the image, element `k = i*WIN_W + j` of `win_pix` (bits `k*PIX_W +: PIX_W`) holds pixel (`y+i`, `x+j`), for 0 <= i < `WIN_H` and 0 <= j < `WIN_W`.
- R3: R2 holds when `x` is not a multiple of `WIN_W`. Pixel column `c` is kept in bank `c mod WIN_W` at bank column `c div WIN_W`. Banks below `x mod WIN_W` read bank column `x div WIN_W + 1`, and the others read `x div WIN_W`.
- R4: A read with `y + WIN_H > ROWS` or `x + WIN_W > COLS` sets `win_err` in the following cycle, and the content of `win_pix` is then undefined. A read that fits, including one that ends exactly on the last row or column, clears `win_err`.
- R5: A write with `wr_en` high stores `wr_data` at (`wr_row`, `wr_col`) and changes no other pixel.
- R6: A read issued in the same cycle as a write returns the image as it was before that write. The next read returns the new pixel.
- R7: While `rst_n` is low at a clock edge, `win_valid` and `win_err` go low.
- R8: During a read that fits, the shared row decoder drives exactly `WIN_H` wordlines, and they are rows `y` through `y+WIN_H-1`.
- R9: While `rd_en` is low, `win_pix` and `win_err` keep their values, even when writes change pixels inside the last window read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write one pixel this cycle |
| wr_row | input | $clog2(ROWS) | Row of the pixel written |
| wr_col | input | $clog2(COLS) | Column of the pixel written |
| wr_data | input | PIX_W | Pixel value written |
| rd_en | input | 1 | Read a window this cycle |
| org_row | input | $clog2(ROWS) | Top row of the window |
| org_col | input | $clog2(COLS) | Left column of the window |
| win_valid | output | 1 | Window result is from the previous cycle's read |
| win_err | output | 1 | Last window read did not fit in the image |
| win_pix | output | WIN_H*WIN_W*PIX_W | Window pixels, row-major, element 0 at the origin |

## Verification
The image is filled with random values, so each window has distinct contents and a mixed-up bank or row shows up as a wrong element. Directed origins cover the first corner, the last legal corner, and single-step overshoots past the bottom and the right edge. The last two tell apart an off-by-one in the bounds test from a correct flag. Origins at every column phase separate a correct per-bank column offset from one that only works on aligned windows. A random stream of origins over the whole image, and reads that overlap a write or follow a write, checks the window order and the ordering of reads and writes.

// File: rtl/pwin_pkg.sv
// Package pwin_pkg
// Shared helpers for the parallel window memory. These are pure functions
// with no state. They assume a column interleave over a number of banks
// equal to the window width.
package pwin_pkg;

    // Bank column that bank b must read for a window whose left column is x.
    function automatic int bank_column(input int x, input int b, input int nbanks);
        return (x / nbanks) + ((b < (x % nbanks)) ? 1 : 0);
    endfunction

    // Bank that holds image column c.
    function automatic int bank_of(input int c, input int nbanks);
        return c % nbanks;
    endfunction

endpackage

// File: rtl/pwin_row_decode.sv
// Module pwin_row_decode
// Shared row decoder. From one base row it produces one one-hot select per
// window row (slot): slot i selects image row base+i. A slot whose row falls
// below the image selects nothing. It is purely combinational and is shared
// by every bank.
module pwin_row_decode #(
    parameter int ROWS  = 16,
    parameter int WIN_H = 4,
    localparam int RW   = $clog2(ROWS)
) (
    input  logic [RW-1:0]                  base_row,
    output logic [WIN_H-1:0][ROWS-1:0]     slot_sel
);

    // One comparator per (slot, row) pair drives that slot's wordline.
    always_comb begin
        for (int i = 0; i < WIN_H; i++) begin
            for (int r = 0; r < ROWS; r++) begin
                slot_sel[i][r] = (r == int'(base_row) + i);
            end
        end
    end

endmodule

// File: rtl/pwin_col_select.sv
// Module pwin_col_select
// Per-bank column select. For a window left column it gives each bank the
// bank column to read. Banks whose index is below the column phase have
// already wrapped, so they read one bank column further right. col_ok is
// low when the computed column lies past the image (window out of range).
module pwin_col_select
    import pwin_pkg::*;
#(
    parameter int COLS  = 16,
    parameter int WIN_W = 4,
    localparam int CW    = $clog2(COLS),
    localparam int BCOLS = COLS / WIN_W,
    localparam int BCW   = $clog2(BCOLS)
) (
    input  logic [CW-1:0]                 org_col,
    output logic [WIN_W-1:0][BCW-1:0]     bcol,
    output logic [WIN_W-1:0]              col_ok
);

    // Offset and range check for each bank, computed in parallel.
    always_comb begin
        int bc;
        for (int b = 0; b < WIN_W; b++) begin
            bc        = bank_column(int'(org_col), b, WIN_W);
            col_ok[b] = (bc < BCOLS);
            bcol[b]   = col_ok[b] ? BCW'(bc) : '0;
        end
    end

endmodule

// File: rtl/pwin_bank.sv
// Module pwin_bank
// One storage bank holding every WIN_W-th image column. It has a synchronous
// single-pixel write. The read is combinational: for each slot it returns
// the pixel at the slot's selected row and the given bank column. It assumes
// slot selects are one-hot or zero. A zero slot, or a column that is not
// valid, returns zero.
module pwin_bank #(
    parameter int ROWS  = 16,
    parameter int BCOLS = 4,
    parameter int WIN_H = 4,
    parameter int PIX_W = 8,
    localparam int RW   = $clog2(ROWS),
    localparam int BCW  = $clog2(BCOLS)
) (
    input  logic                          clk,
    input  logic                          wr_en,
    input  logic [RW-1:0]                 wr_row,
    input  logic [BCW-1:0]                wr_bcol,
    input  logic [PIX_W-1:0]              wr_data,
    input  logic [WIN_H-1:0][ROWS-1:0]    slot_sel,
    input  logic [BCW-1:0]                rd_bcol,
    input  logic                          rd_ok,
    output logic [WIN_H-1:0][PIX_W-1:0]   slot_pix
);

    logic [PIX_W-1:0] cells [ROWS][BCOLS];

    // Pixel store: one write per cycle, no reset (content comes from writes).
    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_row][wr_bcol] <= wr_data;
        end
    end

    // Multi-wordline read: each slot ORs the cells of its active row.
    always_comb begin
        for (int i = 0; i < WIN_H; i++) begin
            slot_pix[i] = '0;
            for (int r = 0; r < ROWS; r++) begin
                if (slot_sel[i][r] && rd_ok) begin
                    slot_pix[i] = slot_pix[i] | cells[r][rd_bcol];
                end
            end
        end
    end

endmodule

// File: rtl/pwin_mem.sv
// Module pwin_mem
// Top of the parallel window memory. Columns are interleaved over WIN_W
// banks. A shared row decoder and per-bank column selects fetch a whole
// window. A crossbar restores row-major window order, and the result is
// registered (one cycle latency). It assumes COLS is a multiple of WIN_W,
// WIN_W >= 2, WIN_W < COLS and WIN_H < ROWS.
module pwin_mem
    import pwin_pkg::*;
#(
    parameter int ROWS  = 16,
    parameter int COLS  = 16,
    parameter int WIN_H = 4,
    parameter int WIN_W = 4,
    parameter int PIX_W = 8,
    localparam int RW    = $clog2(ROWS),
    localparam int CW    = $clog2(COLS),
    localparam int BCOLS = COLS / WIN_W,
    localparam int BCW   = $clog2(BCOLS),
    localparam int BW    = $clog2(WIN_W),
    localparam int NPIX  = WIN_H * WIN_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [RW-1:0]           wr_row,
    input  logic [CW-1:0]           wr_col,
    input  logic [PIX_W-1:0]        wr_data,
    input  logic                    rd_en,
    input  logic [RW-1:0]           org_row,
    input  logic [CW-1:0]           org_col,
    output logic                    win_valid,
    output logic                    win_err,
    output logic [NPIX*PIX_W-1:0]   win_pix
);

    logic [WIN_H-1:0][ROWS-1:0]             slot_sel;
    logic [WIN_W-1:0][BCW-1:0]              bcol;
    logic [WIN_W-1:0]                       col_ok;
    logic [WIN_W-1:0][WIN_H-1:0][PIX_W-1:0] bank_pix;
    logic [NPIX*PIX_W-1:0]                  win_next;
    logic                                   fits;
    logic [ROWS-1:0]                        wl_union;
    logic [BCW-1:0]                         wr_bcol;

    assign fits    = (int'(org_row) + WIN_H <= ROWS) && (int'(org_col) + WIN_W <= COLS);
    assign wr_bcol = BCW'(int'(wr_col) / WIN_W);

    pwin_row_decode #(.ROWS(ROWS), .WIN_H(WIN_H)) u_rowdec (
        .base_row (org_row),
        .slot_sel (slot_sel)
    );

    pwin_col_select #(.COLS(COLS), .WIN_W(WIN_W)) u_colsel (
        .org_col (org_col),
        .bcol    (bcol),
        .col_ok  (col_ok)
    );

    for (genvar b = 0; b < WIN_W; b++) begin : g_bank
        logic bank_we;
        // Write steering: only the bank owning the column takes the write.
        assign bank_we = wr_en && (bank_of(int'(wr_col), WIN_W) == b);

        pwin_bank #(.ROWS(ROWS), .BCOLS(BCOLS), .WIN_H(WIN_H), .PIX_W(PIX_W)) u_bank (
            .clk      (clk),
            .wr_en    (bank_we),
            .wr_row   (wr_row),
            .wr_bcol  (wr_bcol),
            .wr_data  (wr_data),
            .slot_sel (slot_sel),
            .rd_bcol  (bcol[b]),
            .rd_ok    (col_ok[b]),
            .slot_pix (bank_pix[b])
        );
    end

    // Output crossbar: window column j comes from bank (x+j) mod WIN_W.
    always_comb begin
        logic [BW-1:0] bsel;
        for (int i = 0; i < WIN_H; i++) begin
            for (int j = 0; j < WIN_W; j++) begin
                bsel = BW'(bank_of(int'(org_col) + j, WIN_W));
                win_next[(i*WIN_W + j)*PIX_W +: PIX_W] = bank_pix[bsel][i];
            end
        end
    end

    // Union of active wordlines, used only to check the shared decoder.
    always_comb begin
        wl_union = '0;
        for (int i = 0; i < WIN_H; i++) begin
            wl_union = wl_union | slot_sel[i];
        end
    end

    // Result register: captures window and range flag on each read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_valid <= 1'b0;
            win_err   <= 1'b0;
            win_pix   <= '0;
        end else begin
            win_valid <= rd_en;
            if (rd_en) begin
                win_err <= !fits;
                win_pix <= win_next;
            end
        end
    end

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> win_valid);

    // R1
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !win_valid);

    // R4
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ((int'(org_row) > ROWS - WIN_H) || (int'(org_col) > COLS - WIN_W))) |=> win_err);

    // R4
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (int'(org_row) <= ROWS - WIN_H) && (int'(org_col) <= COLS - WIN_W)) |=> !win_err);

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!win_valid && !win_err));

    // R8
    wl_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && fits) |-> ($countones(wl_union) == WIN_H));

    // R8
    wl_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && fits) |-> wl_union[org_row]);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> ($stable(win_pix) && $stable(win_err)));

    for (genvar b = 0; b < WIN_W; b++) begin : g_colchk
        // R3
        bank_col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && fits) |-> (col_ok[b] &&
                (int'(bcol[b]) == int'(org_col) / WIN_W ||
                 int'(bcol[b]) == int'(org_col) / WIN_W + 1)));
    end

endmodule

// File: tb/tb_pwin_mem.sv
// Bench for pwin_mem: random image, directed and random window reads,
// checked against a flat reference image kept in the bench.
module tb_pwin_mem;

    localparam int ROWS = 16, COLS = 16, WH = 4, WW = 4, PW = 8;
    localparam int NP = WH * WW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [3:0] wr_row = '0, wr_col = '0;
    logic [PW-1:0] wr_data = '0;
    logic rd_en = 1'b0;
    logic [3:0] org_row = '0, org_col = '0;
    logic win_valid, win_err;
    logic [NP*PW-1:0] win_pix;

    logic [PW-1:0] ref_img [ROWS][COLS];
    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    pwin_mem dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data),
        .rd_en(rd_en), .org_row(org_row), .org_col(org_col),
        .win_valid(win_valid), .win_err(win_err), .win_pix(win_pix)
    );

    function automatic logic [NP*PW-1:0] expect_win(input int y, input int x);
        logic [NP*PW-1:0] v;
        for (int i = 0; i < WH; i++)
            for (int j = 0; j < WW; j++)
                v[(i*WW + j)*PW +: PW] = ref_img[y+i][x+j];
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic write_px(input int r, input int c, input logic [PW-1:0] d);
        wr_en = 1'b1; wr_row = 4'(r); wr_col = 4'(c); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        ref_img[r][c] = d;
    endtask

    // One read: drive at negedge, check after the capturing edge.
    task automatic read_win(input int y, input int x);
        bit bad;
        logic [NP*PW-1:0] exp;
        bad = (y + WH > ROWS) || (x + WW > COLS);
        if (!bad) exp = expect_win(y, x);
        rd_en = 1'b1; org_row = 4'(y); org_col = 4'(x);
        @(negedge clk);
        rd_en = 1'b0;
        chk(win_valid == 1'b1, "R1 valid after read", 128'(win_valid), 128'(1));
        chk(win_err == bad, "R4 range flag", 128'(win_err), 128'(bad));
        if (!bad) begin
            if (x % WW != 0) chk(win_pix == exp, "R3 unaligned window", win_pix, exp);
            else             chk(win_pix == exp, "R2 aligned window", win_pix, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R7: reset state
        chk(!win_valid && !win_err, "R7 reset state", 128'({win_valid, win_err}), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(!win_valid, "R1 idle after reset", 128'(win_valid), 128'(0));

        // R5: fill the whole image with random pixels
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                write_px(r, c, PW'($urandom));

        // Directed corners; R8: the last legal window uses rows 12..15
        read_win(0, 0);
        read_win(ROWS - WH, COLS - WW);
        read_win(ROWS - WH + 1, 0);
        read_win(0, COLS - WW + 1);
        read_win(15, 15);
        for (int p = 0; p < WW; p++) read_win(5, 4 + p);   // R3 every phase

        // R5: single write changes only that pixel (neighbours in same window)
        write_px(7, 6, 8'hA5);
        read_win(6, 5);

        // R6: read in the same cycle as a write sees old data
        begin
            logic [NP*PW-1:0] old_w;
            old_w = expect_win(2, 3);
            rd_en = 1'b1; org_row = 4'd2; org_col = 4'd3;
            wr_en = 1'b1; wr_row = 4'd3; wr_col = 4'd5; wr_data = ~ref_img[3][5];
            @(negedge clk);
            rd_en = 1'b0; wr_en = 1'b0;
            chk(win_pix == old_w, "R6 same-cycle read old", win_pix, old_w);
            ref_img[3][5] = wr_data;
            read_win(2, 3);
        end

        // R9: idle cycles with writes inside the held window
        begin
            logic [NP*PW-1:0] held;
            read_win(8, 8);
            held = win_pix;
            write_px(9, 9, ~ref_img[9][9]);
            write_px(8, 11, ~ref_img[8][11]);
            chk(win_pix == held && !win_valid, "R9 hold while idle", win_pix, held);
            read_win(8, 8);
        end

        // Random origins over the whole image, with occasional writes
        for (int n = 0; n < 300; n++) begin
            if ($urandom % 4 == 0) write_px(int'($urandom % ROWS), int'($urandom % COLS), PW'($urandom));
            read_win(int'($urandom % ROWS), int'($urandom % COLS));
        end

        summary();
        $finish;
    end

endmodule